// File: doc/BRIEF.md
# Clock Output Stop and Power-Up Controller

This block sits between the free-running reference clocks of a clock generator and its output pins. It owns a set of differential pairs (a group of processor-class pairs, a group of peripheral-serial-class pairs and one shared pair) and a group of single-ended bus clocks. For every output it produces a data value and a separate drive-enable. A low drive-enable stands for a tri-stated pin. A power-up sequencer brings the outputs up from a power-good strobe and latches a role strap when it does so. After that, a processor stop pin, a bus stop pin, a power-down pin and two clock-request pins halt outputs. Per-output configuration bits, presented on a parallel bus, choose which outputs each source may halt and how each halted output parks.

The sequencer has four states. `SEQ_OFF` waits for power-good. `SEQ_WAIT` counts the start-up delay. `SEQ_ACTIVE` is normal running and `SEQ_PDOWN` is power-down. The transitions are:
- power-good seen: `SEQ_OFF` to `SEQ_WAIT`.
- power-good lost during the count: `SEQ_WAIT` to `SEQ_OFF`.
- count done: `SEQ_WAIT` to `SEQ_ACTIVE`, or to `SEQ_PDOWN` when power-down was requested early.
- power-down raised: `SEQ_ACTIVE` to `SEQ_PDOWN`.
- power-down released: `SEQ_PDOWN` to `SEQ_ACTIVE`.

Each output holds a registered gate state: closed, running, parked-driven or parked-tri-state. The gate state is reloaded only on a clock edge at which that output's reference is low. This means no stop or start ever cuts a pulse short.

Top module: `clkstop_top`

## Requirements
- R1: From reset until the sequencer leaves its start-up count, every pair and bus clock has data 0 and drive-enable 0.
- R2: When `pwrgd_n` is sampled low in the off state, the strap is latched and the count starts at 0. Each wait cycle either finishes, when the count equals `cfg_delay`, or adds one to the count. This gives `cfg_delay`+1 wait cycles before the gates may open. If `pwrgd_n` is sampled high during the wait, the sequencer returns to the off state.
- R3: Once the wait has finished, changes on `pwrgd_n` and `strap_shared_cpu` have no effect until `rst_n` is asserted.
- R4: The last pair (index N_CPU+N_SRC) follows processor rules and `cpu_ref` when the latched strap is 1. It follows peripheral rules and `src_ref` when the latched strap is 0.
- R5: While `cpu_stop_n` is low, a processor-role pair whose `cfg_stoppable` bit is 1 halts. A pair whose bit is 0 keeps toggling. A halted pair whose `cfg_stop_tri` bit is 0 parks driven with true=1 and complement=0. When the bit is 1, the pair parks tri-stated.
- R6: A peripheral-role pair halts when either of these holds:
  - `req_a_n` is high and its `cfg_req_a` bit is 1, or `req_b_n` is high and its `cfg_req_b` bit is 1.
  - `pci_stop_n` is low and its `cfg_pcistop` bit is 1.
  A request pin whose bit is 0 has no effect on the pair. A halted pair parks according to `cfg_stop_tri`, as in R5.
- R7: `pwr_dn` sampled high while active enters power-down on the next edge, and `pwr_dn` sampled low leaves it. In power-down every pair parks driven (true=1, complement=0) when its `cfg_pd_tri` bit is 0 and tri-stated when the bit is 1. Every enabled bus clock is driven low. Power-down overrides all stop sources.
- R8: `pwr_dn` is sampled high while the wait count is below PD_WIN. The sequencer then goes straight from the wait to power-down. If `pwr_dn` rises only later in the wait, the block first comes up running.
- R9: A bus clock with `cfg_pci_en`=0 has data 0 and drive-enable 0. While `pci_stop_n` is low, a bus clock with `cfg_pci_stoppable`=1 is driven low. Otherwise the bus clock follows `pci_ref`.
- R10: A running pair drives true=reference and complement=its inverse. An output's gate state changes only at a clock edge where its reference was sampled low, so a released output resumes with a full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrgd_n | input | 1 | Power-good strobe, active low |
| strap_shared_cpu | input | 1 | Role strap for the shared pair (1 = processor role) |
| cfg_delay | input | DLY_W | Start-up wait length minus one, in clk cycles |
| cpu_ref | input | 1 | Processor-class reference clock |
| src_ref | input | 1 | Peripheral-class reference clock |
| pci_ref | input | 1 | Bus-clock reference |
| cpu_stop_n | input | 1 | Processor stop, active low |
| pci_stop_n | input | 1 | Bus stop, active low |
| pwr_dn | input | 1 | Power-down, active high |
| req_a_n | input | 1 | Clock request A, active low (high stops) |
| req_b_n | input | 1 | Clock request B, active low (high stops) |
| cfg_stoppable | input | NP | Per pair: halted by processor stop |
| cfg_pd_tri | input | NP | Per pair: power-down parks tri-stated |
| cfg_stop_tri | input | NP | Per pair: stop parks tri-stated |
| cfg_req_a | input | NP | Per pair: halted by request A |
| cfg_req_b | input | NP | Per pair: halted by request B |
| cfg_pcistop | input | NP | Per pair: halted by bus stop |
| cfg_pci_en | input | N_PCI | Per bus clock: enable |
| cfg_pci_stoppable | input | N_PCI | Per bus clock: halted by bus stop |
| pair_t | output | NP | True side of each pair |
| pair_c | output | NP | Complement side of each pair |
| pair_oe | output | NP | Drive-enable of each pair |
| pci_clk | output | N_PCI | Bus clock data |
| pci_oe | output | N_PCI | Bus clock drive-enable |

## Verification
The references toggle at random every cycle, so gate reloads sometimes wait through several high samples. This separates low-boundary gating from immediate gating. Stop pins, request pins and the configuration vectors change at random under both strap values, which separates processor from peripheral rules on the shared pair and driven from tri-stated parking. Directed runs cover the following:
- an aborted power-up, a zero-length wait, and toggling power-good and strap after enable;
- a power-down pulse inside the boot window, which must bring the outputs up parked;
- a power-down rise after the boot window, which must let them come up running first.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_WAIT   = 2'd1,
        SEQ_ACTIVE = 2'd2,
        SEQ_PDOWN  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_RUN  = 2'd1,
        GATE_PARK = 2'd2,
        GATE_TRI  = 2'd3
    } gate_e;

    // Parking style selected by a per-output drive-mode bit.
    function automatic gate_e park_mode(input logic tri_sel);
        return tri_sel ? GATE_TRI : GATE_PARK;
    endfunction

endpackage

// File: rtl/clkstop_seq.sv
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int DLY_W  = 18,
    parameter int PD_WIN = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrgd_n,
    input  logic             pwr_dn,
    input  logic             strap_in,
    input  logic [DLY_W-1:0] cfg_delay,
    output logic             out_en,
    output logic             pd_now,
    output logic             strap_q
);

    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             boot_q, boot_d;
    logic             strap_d;
    logic             in_win;
    logic             delay_done;

    assign in_win     = (32'(cnt_q) < 32'(PD_WIN));
    assign delay_done = (cnt_q == cfg_delay);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
            cnt_q   <= '0;
            boot_q  <= 1'b0;
            strap_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            boot_q  <= boot_d;
            strap_q <= strap_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        boot_d  = boot_q;
        strap_d = strap_q;
        unique case (state_q)
            SEQ_OFF: begin
                if (!pwrgd_n) begin
                    state_d = SEQ_WAIT;
                    cnt_d   = '0;
                    boot_d  = 1'b0;
                    strap_d = strap_in;
                end
            end
            SEQ_WAIT: begin
                if (pwrgd_n) begin
                    state_d = SEQ_OFF;
                end else begin
                    boot_d = boot_q | (pwr_dn & in_win);
                    if (delay_done) begin
                        state_d = boot_d ? SEQ_PDOWN : SEQ_ACTIVE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SEQ_ACTIVE: begin
                if (pwr_dn) state_d = SEQ_PDOWN;
            end
            SEQ_PDOWN: begin
                if (!pwr_dn) state_d = SEQ_ACTIVE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        out_en = 1'b0;
        pd_now = 1'b0;
        unique case (state_q)
            SEQ_OFF, SEQ_WAIT: begin
                out_en = 1'b0;
                pd_now = 1'b0;
            end
            SEQ_ACTIVE: begin
                out_en = 1'b1;
                pd_now = 1'b0;
            end
            SEQ_PDOWN: begin
                out_en = 1'b1;
                pd_now = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/clkstop_pair.sv
module clkstop_pair
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic out_en,
    input  logic pd_now,
    input  logic cpu_role,
    input  logic cpu_stop,
    input  logic pci_stop,
    input  logic req_a_off,
    input  logic req_b_off,
    input  logic cfg_stoppable,
    input  logic cfg_pd_tri,
    input  logic cfg_stop_tri,
    input  logic cfg_req_a,
    input  logic cfg_req_b,
    input  logic cfg_pcistop,
    output logic out_t,
    output logic out_c,
    output logic out_oe
);

    gate_e gate_q, gate_d;
    logic  src_halt;
    logic  cpu_halt;

    always_comb begin
        src_halt = (req_a_off & cfg_req_a) | (req_b_off & cfg_req_b) |
                   (pci_stop & cfg_pcistop);
        cpu_halt = cpu_stop & cfg_stoppable;
        if (!out_en) begin
            gate_d = GATE_OFF;
        end else if (pd_now) begin
            gate_d = park_mode(cfg_pd_tri);
        end else if (cpu_role) begin
            gate_d = cpu_halt ? park_mode(cfg_stop_tri) : GATE_RUN;
        end else begin
            gate_d = src_halt ? park_mode(cfg_stop_tri) : GATE_RUN;
        end
    end

    // Gate reloads only while the reference is low: no runt pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GATE_OFF;
        end else if (!ref_in) begin
            gate_q <= gate_d;
        end
    end

    always_comb begin
        out_t  = 1'b0;
        out_c  = 1'b0;
        out_oe = 1'b0;
        unique case (gate_q)
            GATE_RUN: begin
                out_t  = ref_in;
                out_c  = ~ref_in;
                out_oe = 1'b1;
            end
            GATE_PARK: begin
                out_t  = 1'b1;
                out_c  = 1'b0;
                out_oe = 1'b1;
            end
            GATE_OFF, GATE_TRI: begin
                out_t  = 1'b0;
                out_c  = 1'b0;
                out_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkstop_pci.sv
module clkstop_pci
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic out_en,
    input  logic pd_now,
    input  logic pci_stop,
    input  logic cfg_en,
    input  logic cfg_stoppable,
    output logic out_clk,
    output logic out_oe
);

    gate_e gate_q, gate_d;

    always_comb begin
        if (!out_en || !cfg_en) begin
            gate_d = GATE_OFF;
        end else if (pd_now || (pci_stop && cfg_stoppable)) begin
            gate_d = GATE_PARK;
        end else begin
            gate_d = GATE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GATE_OFF;
        end else if (!ref_in) begin
            gate_q <= gate_d;
        end
    end

    always_comb begin
        out_clk = 1'b0;
        out_oe  = 1'b0;
        unique case (gate_q)
            GATE_RUN: begin
                out_clk = ref_in;
                out_oe  = 1'b1;
            end
            GATE_PARK: begin
                out_clk = 1'b0;
                out_oe  = 1'b1;
            end
            GATE_OFF, GATE_TRI: begin
                out_clk = 1'b0;
                out_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkstop_top.sv
module clkstop_top #(
    parameter int N_CPU  = 2,
    parameter int N_SRC  = 7,
    parameter int N_PCI  = 4,
    parameter int DLY_W  = 18,
    parameter int PD_WIN = 1000,
    localparam int NP    = N_CPU + N_SRC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrgd_n,
    input  logic             strap_shared_cpu,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             cpu_ref,
    input  logic             src_ref,
    input  logic             pci_ref,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn,
    input  logic             req_a_n,
    input  logic             req_b_n,
    input  logic [NP-1:0]    cfg_stoppable,
    input  logic [NP-1:0]    cfg_pd_tri,
    input  logic [NP-1:0]    cfg_stop_tri,
    input  logic [NP-1:0]    cfg_req_a,
    input  logic [NP-1:0]    cfg_req_b,
    input  logic [NP-1:0]    cfg_pcistop,
    input  logic [N_PCI-1:0] cfg_pci_en,
    input  logic [N_PCI-1:0] cfg_pci_stoppable,
    output logic [NP-1:0]    pair_t,
    output logic [NP-1:0]    pair_c,
    output logic [NP-1:0]    pair_oe,
    output logic [N_PCI-1:0] pci_clk,
    output logic [N_PCI-1:0] pci_oe
);

    localparam int SH = NP - 1;

    logic out_en;
    logic pd_now;
    logic strap_q;
    logic cpu_stop;
    logic pci_stop;

    assign cpu_stop = ~cpu_stop_n;
    assign pci_stop = ~pci_stop_n;

    clkstop_seq #(
        .DLY_W  (DLY_W),
        .PD_WIN (PD_WIN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrgd_n   (pwrgd_n),
        .pwr_dn    (pwr_dn),
        .strap_in  (strap_shared_cpu),
        .cfg_delay (cfg_delay),
        .out_en    (out_en),
        .pd_now    (pd_now),
        .strap_q   (strap_q)
    );

    for (genvar i = 0; i < NP; i++) begin : g_pair
        logic role_cpu;
        logic pref;
        if (i < N_CPU) begin : g_cpu
            assign role_cpu = 1'b1;
        end else if (i == SH) begin : g_shared
            assign role_cpu = strap_q;
        end else begin : g_src
            assign role_cpu = 1'b0;
        end
        assign pref = role_cpu ? cpu_ref : src_ref;

        clkstop_pair u_pair (
            .clk           (clk),
            .rst_n         (rst_n),
            .ref_in        (pref),
            .out_en        (out_en),
            .pd_now        (pd_now),
            .cpu_role      (role_cpu),
            .cpu_stop      (cpu_stop),
            .pci_stop      (pci_stop),
            .req_a_off     (req_a_n),
            .req_b_off     (req_b_n),
            .cfg_stoppable (cfg_stoppable[i]),
            .cfg_pd_tri    (cfg_pd_tri[i]),
            .cfg_stop_tri  (cfg_stop_tri[i]),
            .cfg_req_a     (cfg_req_a[i]),
            .cfg_req_b     (cfg_req_b[i]),
            .cfg_pcistop   (cfg_pcistop[i]),
            .out_t         (pair_t[i]),
            .out_c         (pair_c[i]),
            .out_oe        (pair_oe[i])
        );
    end

    for (genvar k = 0; k < N_PCI; k++) begin : g_pci
        clkstop_pci u_pci (
            .clk           (clk),
            .rst_n         (rst_n),
            .ref_in        (pci_ref),
            .out_en        (out_en),
            .pd_now        (pd_now),
            .pci_stop      (pci_stop),
            .cfg_en        (cfg_pci_en[k]),
            .cfg_stoppable (cfg_pci_stoppable[k]),
            .out_clk       (pci_clk[k]),
            .out_oe        (pci_oe[k])
        );
    end

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
    parameter int NP    = 10,
    parameter int N_CPU = 2,
    parameter int N_PCI = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_en,
    input logic             strap_q,
    input logic             cpu_ref,
    input logic             pci_ref,
    input logic [NP-1:0]    pair_t,
    input logic [NP-1:0]    pair_c,
    input logic [NP-1:0]    pair_oe,
    input logic [N_PCI-1:0] pci_oe
);

    // R1
    quiet_before_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (pair_oe == '0 && pci_oe == '0));

    // R3
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_en) |-> out_en);

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> $stable(strap_q));

    for (genvar i = 0; i < NP; i++) begin : g_pair_chk
        // R5
        pair_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pair_oe[i] |-> (pair_t[i] != pair_c[i]));
    end

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
        // R10
        cpu_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pair_oe[i]) || $fell(pair_oe[i])) |-> !$past(cpu_ref));
    end

    for (genvar k = 0; k < N_PCI; k++) begin : g_pci_chk
        // R9
        pci_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pci_oe[k]) || $fell(pci_oe[k])) |-> !$past(pci_ref));
    end

endmodule

bind clkstop_top clkstop_chk #(
    .NP    (NP),
    .N_CPU (N_CPU),
    .N_PCI (N_PCI)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_en  (out_en),
    .strap_q (strap_q),
    .cpu_ref (cpu_ref),
    .pci_ref (pci_ref),
    .pair_t  (pair_t),
    .pair_c  (pair_c),
    .pair_oe (pair_oe),
    .pci_oe  (pci_oe)
);

// File: tb/sim_clkstop_top.sv
module sim_clkstop_top;

    localparam int N_CPU  = 2;
    localparam int N_SRC  = 7;
    localparam int N_PCI  = 4;
    localparam int DLY_W  = 18;
    localparam int PD_WIN = 8;
    localparam int NP     = N_CPU + N_SRC + 1;
    localparam int SH     = NP - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwrgd_n = 1'b1;
    logic             strap_shared_cpu = 1'b0;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic             cpu_ref = 1'b0, src_ref = 1'b0, pci_ref = 1'b0;
    logic             cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn = 1'b0;
    logic             req_a_n = 1'b0, req_b_n = 1'b0;
    logic [NP-1:0]    cfg_stoppable = '0, cfg_pd_tri = '0, cfg_stop_tri = '0;
    logic [NP-1:0]    cfg_req_a = '0, cfg_req_b = '0, cfg_pcistop = '0;
    logic [N_PCI-1:0] cfg_pci_en = '0, cfg_pci_stoppable = '0;
    logic [NP-1:0]    pair_t, pair_c, pair_oe;
    logic [N_PCI-1:0] pci_clk, pci_oe;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    string phase   = "R1 reset";

    // Reference model state (gate codes: 0 closed, 1 run, 2 park, 3 tri)
    int    m_st = 0;
    int    m_cnt = 0;
    bit    m_strap = 1'b0;
    bit    m_boot = 1'b0;
    int    m_gate [NP];
    int    m_pgate[N_PCI];
    string m_why  [NP];

    always #5 clk = ~clk;

    clkstop_top #(
        .N_CPU(N_CPU), .N_SRC(N_SRC), .N_PCI(N_PCI), .DLY_W(DLY_W), .PD_WIN(PD_WIN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_shared_cpu(strap_shared_cpu),
        .cfg_delay(cfg_delay), .cpu_ref(cpu_ref), .src_ref(src_ref), .pci_ref(pci_ref),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn(pwr_dn),
        .req_a_n(req_a_n), .req_b_n(req_b_n), .cfg_stoppable(cfg_stoppable),
        .cfg_pd_tri(cfg_pd_tri), .cfg_stop_tri(cfg_stop_tri), .cfg_req_a(cfg_req_a),
        .cfg_req_b(cfg_req_b), .cfg_pcistop(cfg_pcistop), .cfg_pci_en(cfg_pci_en),
        .cfg_pci_stoppable(cfg_pci_stoppable), .pair_t(pair_t), .pair_c(pair_c),
        .pair_oe(pair_oe), .pci_clk(pci_clk), .pci_oe(pci_oe)
    );

    function automatic bit role_cpu(int i);
        return (i < N_CPU) || (i == SH && m_strap);
    endfunction

    function automatic bit pair_ref(int i);
        return role_cpu(i) ? cpu_ref : src_ref;
    endfunction

    function automatic int park(bit tri_sel);
        return tri_sel ? 3 : 2;
    endfunction

    // R4 R5 R6 R7: desired gate for a pair
    function automatic int want_pair(int i, bit en, bit pd, output string why);
        if (!en) begin why = "R1 closed before enable"; return 0; end
        if (pd) begin why = "R7 power-down parking"; return park(cfg_pd_tri[i]); end
        if (role_cpu(i)) begin
            why = (i == SH) ? "R4 shared pair cpu role" : "R5 cpu stop";
            return (!cpu_stop_n && cfg_stoppable[i]) ? park(cfg_stop_tri[i]) : 1;
        end
        why = (i == SH) ? "R4 shared pair src role" : "R6 request/bus stop";
        if ((req_a_n && cfg_req_a[i]) || (req_b_n && cfg_req_b[i]) ||
            (!pci_stop_n && cfg_pcistop[i])) return park(cfg_stop_tri[i]);
        return 1;
    endfunction

    // R9: desired gate for a bus clock
    function automatic int want_pci(int k, bit en, bit pd);
        if (!en || !cfg_pci_en[k]) return 0;
        if (pd || (!pci_stop_n && cfg_pci_stoppable[k])) return 2;
        return 1;
    endfunction

    // R10: expected {t,c,oe}
    function automatic logic [2:0] exp_pair(int g, bit r);
        case (g)
            1: return {r, ~r, 1'b1};
            2: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [1:0] exp_pci(int g, bit r);
        case (g)
            1: return {r, 1'b1};
            2: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < NP; i++) begin m_gate[i] = 0; m_why[i] = "R1 reset"; end
        for (int k = 0; k < N_PCI; k++) m_pgate[k] = 0;
    end

    // Model update on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_strap = 1'b0; m_boot = 1'b0;
            for (int i = 0; i < NP; i++) begin m_gate[i] = 0; m_why[i] = "R1 reset"; end
            for (int k = 0; k < N_PCI; k++) m_pgate[k] = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                string w;
                int    g;
                g = want_pair(i, m_st >= 2, m_st == 3, w);
                if (!pair_ref(i)) begin m_gate[i] = g; m_why[i] = w; end
            end
            for (int k = 0; k < N_PCI; k++)
                if (!pci_ref) m_pgate[k] = want_pci(k, m_st >= 2, m_st == 3);
            case (m_st)
                0: if (!pwrgd_n) begin
                       m_st = 1; m_cnt = 0; m_boot = 1'b0; m_strap = strap_shared_cpu;
                   end
                1: if (pwrgd_n) m_st = 0;
                   else begin
                       if (pwr_dn && m_cnt < PD_WIN) m_boot = 1'b1;
                       if (m_cnt == int'(cfg_delay)) m_st = m_boot ? 3 : 2;
                       else m_cnt++;
                   end
                2: if (pwr_dn) m_st = 3;
                default: if (!pwr_dn) m_st = 2;
            endcase
        end
    end

    task automatic check_all();
        bit bad;
        bad = 1'b0;
        vectors++;
        for (int i = 0; i < NP; i++) begin
            logic [2:0] e, a;
            e = exp_pair(m_gate[i], pair_ref(i));
            a = {pair_t[i], pair_c[i], pair_oe[i]};
            if (a !== e && !bad) begin
                $display("FAIL [%s | %s] pair %0d t/c/oe got %b expected %b (R10)",
                         phase, m_why[i], i, a, e);
                bad = 1'b1;
            end
        end
        for (int k = 0; k < N_PCI; k++) begin
            logic [1:0] e, a;
            e = exp_pci(m_pgate[k], pci_ref);
            a = {pci_clk[k], pci_oe[k]};
            if (a !== e && !bad) begin
                $display("FAIL [%s | R9 bus clock] pci %0d clk/oe got %b expected %b",
                         phase, k, a, e);
                bad = 1'b1;
            end
        end
        if (bad) fails++;
    endtask

    task automatic rand_cfg();
        cfg_stoppable     = NP'($urandom);
        cfg_pd_tri        = NP'($urandom);
        cfg_stop_tri      = NP'($urandom);
        cfg_req_a         = NP'($urandom);
        cfg_req_b         = NP'($urandom);
        cfg_pcistop       = NP'($urandom);
        cfg_pci_en        = N_PCI'($urandom);
        cfg_pci_stoppable = N_PCI'($urandom);
    endtask

    // One cycle: check at the falling edge, then drive new inputs
    task automatic step(int n, bit rand_pins);
        repeat (n) begin
            @(negedge clk);
            check_all();
            cpu_ref = $urandom_range(1, 0) != 0;
            src_ref = $urandom_range(1, 0) != 0;
            pci_ref = $urandom_range(1, 0) != 0;
            if (rand_pins) begin
                case ($urandom_range(11, 0))
                    0: cpu_stop_n = ~cpu_stop_n;
                    1: pci_stop_n = ~pci_stop_n;
                    2: req_a_n    = ~req_a_n;
                    3: req_b_n    = ~req_b_n;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwrgd_n = 1'b1; pwr_dn = 1'b0;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; req_a_n = 1'b0; req_b_n = 1'b0;
        step(3, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        void'($urandom(32'd1789));
        for (int s = 1; s >= 0; s--) begin
            do_reset();
            rand_cfg();
            phase = "R1 idle before power-good";
            step(6, 1'b1);
            phase = "R2 aborted power-up";
            cfg_delay = 18'd12; strap_shared_cpu = s[0];
            pwrgd_n = 1'b0; step(4, 1'b0);
            pwrgd_n = 1'b1; step(3, 1'b0);
            phase = "R2 power-up delay";
            pwrgd_n = 1'b0; step(20, 1'b0);
            phase = "R3 power-good and strap ignored";
            for (int c = 0; c < 30; c++) begin
                pwrgd_n = $urandom_range(1, 0) != 0;
                strap_shared_cpu = $urandom_range(1, 0) != 0;
                step(1, 1'b1);
            end
            phase = "R4 R5 R6 R9 R10 random stops";
            for (int c = 0; c < 600; c++) begin
                if (c % 25 == 0) rand_cfg();
                step(1, 1'b1);
            end
            phase = "R7 power-down";
            for (int c = 0; c < 200; c++) begin
                if (c % 9 == 0) pwr_dn = $urandom_range(1, 0) != 0;
                if (c % 40 == 0) rand_cfg();
                step(1, 1'b1);
            end
        end
        // R2 zero-length wait
        do_reset(); rand_cfg();
        phase = "R2 zero delay"; cfg_delay = 18'd0; pwrgd_n = 1'b0;
        step(12, 1'b1);
        // R8 power-down inside the boot window
        do_reset(); rand_cfg(); cfg_pd_tri = '0;
        phase = "R8 early power-down"; cfg_delay = 18'd20; pwrgd_n = 1'b0;
        step(2, 1'b0); pwr_dn = 1'b1; step(2, 1'b0); pwr_dn = 1'b0;
        step(30, 1'b0);
        // R8 power-down after the window
        do_reset(); rand_cfg(); cfg_pd_tri = '0;
        phase = "R8 late power-down"; cfg_delay = 18'd20; pwrgd_n = 1'b0;
        step(12, 1'b0); pwr_dn = 1'b1; step(20, 1'b0); pwr_dn = 1'b0;
        step(10, 1'b0);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired in phase %s (R2 sequencing)", phase);
            summary();
            $finish;
        end
    end

endmodule